// File: doc/BRIEF.md
# Boot Region Write-Protection Controller

This block sits in front of the program and erase engine of a word-addressed flash array and decides, for each requested operation, whether it may go ahead and which regions an erase touches. The array is split into four regions: a small boot region at one end, two parameter regions of the same size next to it, and a main region that fills the rest. A module parameter picks whether the boot region sits at the lowest or at the highest addresses.

A one-way lockout flag guards the boot region. While it is clear, the boot region is treated as part of the main erase sector, so erasing one also erases the other. Once it is set, the boot region cannot be programmed or erased and whole-array erase is refused, while the parameter regions and the main region stay writable. A high-voltage indication on the reset pin, presented here as a level input, lifts the lockout for any operation issued while it is high. An identification read at word address 2 reports the flag on data bit 0.

Each request is a one-cycle strobe with an address and an operation code. The verdict, the erase mask and the read data appear on registered outputs one cycle later.

Top module: `boot_wp_ctrl`

## Requirements
- R1: Regions are decoded from the upper address bits (block size 2^BLK_W words). With TOP_BOOT=0, block 0 is boot, block 1 is parameter A, block 2 is parameter B and all higher blocks are main. With TOP_BOOT=1, the order is mirrored from the highest block downward.
- R2: A program request (op_kind 1) never drives erase_mask. It is allowed for any address outside the boot region.
- R3: While unlocked, a sector erase (op_kind 2) whose address is in the boot or main region is allowed, with erase_mask 4'b1001 (bit 0 boot, bit 3 main).
- R4: A sector erase whose address is in a parameter region is allowed with only that region's bit set (bit 1 for parameter A, bit 2 for parameter B), whatever the lock state.
- R5: While locked, a sector erase addressed to the main region gives erase_mask 4'b1000. A sector erase addressed to the boot region is denied with erase_mask 0.
- R6: While locked, a program request to the boot region is denied.
- R7: A chip erase (op_kind 3) is allowed with erase_mask 4'b1111 while unlocked, and denied with erase_mask 0 while locked.
- R8: A request issued with hv_override high is judged as if unlocked. The next request issued with hv_override low is judged by the lock again.
- R9: An identification read (op_kind 0) is never allowed and drives no erase mask. At address 2, id_data bit 0 carries the lock flag and all other bits are 0. At any other address, id_data is 0.
- R10: A lock_set pulse sets the lock flag, which stays set until rst_n. A request in the same cycle as the pulse is judged with the old flag.
- R11: After rst_n the lock flag is clear and all outputs are 0.
- R12: The outputs reflect the request of the previous cycle. With no request, op_done, op_allow, erase_mask and id_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset; also clears the lock flag |
| op_valid | input | 1 | Request strobe, one cycle per request |
| op_kind | input | 2 | 0 id read, 1 program, 2 sector erase, 3 chip erase |
| op_addr | input | ADDR_W | Word address of the request |
| lock_set | input | 1 | Sets the lock flag |
| hv_override | input | 1 | High-voltage override level |
| op_done | output | 1 | A verdict is presented this cycle |
| op_allow | output | 1 | Request may proceed |
| erase_mask | output | 4 | Regions to erase: bit 0 boot, 1 param A, 2 param B, 3 main |
| id_data | output | DATA_W | Identification read data |

## Verification
The bench builds two copies with ADDR_W=6 and BLK_W=2, one for each TOP_BOOT value. This gives 16 blocks of 4 words, so every address, every operation code and both override levels can be swept in each lock state. Each mirrored variant then reaches every region boundary and the identification address. Expected verdicts come from a per-region arithmetic model, and separate directed steps cover a lock pulse issued in the same cycle as a request and the return of protection after the override is removed.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam logic [1:0] OPK_ID   = 2'd0;
  localparam logic [1:0] OPK_PROG = 2'd1;
  localparam logic [1:0] OPK_SECT = 2'd2;
  localparam logic [1:0] OPK_CHIP = 2'd3;

  typedef enum logic [1:0] {
    RG_BOOT  = 2'd0,
    RG_PARA  = 2'd1,
    RG_PARB  = 2'd2,
    RG_MAIN  = 2'd3
  } region_e;

  localparam int unsigned MASK_W = 4;
  localparam int unsigned ID_ADDR = 2;
endpackage

// File: rtl/wp_region_dec.sv
module wp_region_dec
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned BLK_W    = 13,
  parameter bit          TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam int unsigned IDX_W = ADDR_W - BLK_W;

  logic [IDX_W-1:0] blk_raw;
  logic [IDX_W-1:0] blk_idx;

  assign blk_raw = addr[ADDR_W-1:BLK_W];

  generate
    if (TOP_BOOT) begin : g_top
      assign blk_idx = ~blk_raw;
    end else begin : g_bottom
      assign blk_idx = blk_raw;
    end
  endgenerate

  always_comb begin
    if (blk_idx == IDX_W'(0))      region = RG_BOOT;
    else if (blk_idx == IDX_W'(1)) region = RG_PARA;
    else if (blk_idx == IDX_W'(2)) region = RG_PARB;
    else                           region = RG_MAIN;
  end
endmodule

// File: rtl/wp_lock_reg.sv
module wp_lock_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic lock_o
);
  logic lock_nxt;
  logic lock_en;

  always_comb begin
    lock_en  = set_i;
    lock_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_o <= 1'b0;
    else if (lock_en) lock_o <= lock_nxt;
  end
endmodule

// File: rtl/wp_policy.sv
module wp_policy
  import wp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              valid,
  input  logic [1:0]        kind,
  input  region_e           region,
  input  logic              at_id,
  input  logic              locked,
  input  logic              hv,
  output logic              allow,
  output logic [MASK_W-1:0] mask,
  output logic [DATA_W-1:0] rdata
);
  logic open_boot;

  always_comb begin
    open_boot = !locked || hv;
    allow     = 1'b0;
    mask      = '0;
    rdata     = '0;
    if (valid) begin
      unique case (kind)
        OPK_ID: begin
          if (at_id) rdata[0] = locked;
        end
        OPK_PROG: begin
          allow = (region != RG_BOOT) || open_boot;
        end
        OPK_SECT: begin
          unique case (region)
            RG_PARA: begin allow = 1'b1; mask = 4'b0010; end
            RG_PARB: begin allow = 1'b1; mask = 4'b0100; end
            RG_MAIN: begin
              allow = 1'b1;
              mask  = open_boot ? 4'b1001 : 4'b1000;
            end
            default: begin
              allow = open_boot;
              mask  = open_boot ? 4'b1001 : 4'b0000;
            end
          endcase
        end
        default: begin
          allow = open_boot;
          mask  = open_boot ? 4'b1111 : 4'b0000;
        end
      endcase
    end
  end
endmodule

// File: rtl/boot_wp_ctrl.sv
module boot_wp_ctrl
  import wp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned BLK_W    = 13,
  parameter int unsigned DATA_W   = 16,
  parameter bit          TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic              lock_set,
  input  logic              hv_override,
  output logic              op_done,
  output logic              op_allow,
  output logic [3:0]        erase_mask,
  output logic [DATA_W-1:0] id_data
);
  region_e           region;
  logic              lock_q;
  logic              at_id;
  logic              allow_nxt;
  logic [MASK_W-1:0] mask_nxt;
  logic [DATA_W-1:0] rdata_nxt;

  assign at_id = (op_addr == ADDR_W'(ID_ADDR));

  wp_region_dec #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .TOP_BOOT(TOP_BOOT)) u_dec (
    .addr   (op_addr),
    .region (region)
  );

  wp_lock_reg u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (lock_set),
    .lock_o (lock_q)
  );

  wp_policy #(.DATA_W(DATA_W)) u_pol (
    .valid  (op_valid),
    .kind   (op_kind),
    .region (region),
    .at_id  (at_id),
    .locked (lock_q),
    .hv     (hv_override),
    .allow  (allow_nxt),
    .mask   (mask_nxt),
    .rdata  (rdata_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_done    <= 1'b0;
      op_allow   <= 1'b0;
      erase_mask <= '0;
      id_data    <= '0;
    end else begin
      op_done    <= op_valid;
      op_allow   <= allow_nxt;
      erase_mask <= mask_nxt;
      id_data    <= rdata_nxt;
    end
  end
endmodule

// File: rtl/boot_wp_ctrl_chk.sv
module boot_wp_ctrl_chk
  import wp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [1:0] op_kind,
  input logic       lock_set,
  input logic       hv_override,
  input logic       lock_q,
  input logic       op_done,
  input logic       op_allow,
  input logic [3:0] erase_mask
);
  // R7
  chip_lock_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == OPK_CHIP && lock_q && !hv_override
      |=> op_done && !op_allow && erase_mask == 4'b0000);

  // R2
  prog_no_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == OPK_PROG |=> op_done && erase_mask == 4'b0000);

  // R8
  hv_prog_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == OPK_PROG && hv_override |=> op_allow);

  // R9
  id_never_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == OPK_ID |=> !op_allow && erase_mask == 4'b0000);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !op_done && !op_allow && erase_mask == 4'b0000);

  // R12
  mask_needs_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_mask != 4'b0000 |-> op_allow);

  // R10
  lock_from_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(lock_set));
endmodule

bind boot_wp_ctrl boot_wp_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_valid    (op_valid),
  .op_kind     (op_kind),
  .lock_set    (lock_set),
  .hv_override (hv_override),
  .lock_q      (lock_q),
  .op_done     (op_done),
  .op_allow    (op_allow),
  .erase_mask  (erase_mask)
);

// File: tb/sim_boot_wp_ctrl.sv
`timescale 1ns/1ps
module sim_boot_wp_ctrl;
  localparam int AW = 6;
  localparam int BW = 2;
  localparam int DW = 16;
  localparam int NBLK = 1 << (AW - BW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [1:0]    op_kind = 2'd0;
  logic [AW-1:0] op_addr = '0;
  logic          lock_set = 1'b0;
  logic          hv_override = 1'b0;

  logic          done0, allow0, done1, allow1;
  logic [3:0]    mask0, mask1;
  logic [DW-1:0] id0, id1;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit ref_lock = 1'b0;

  always #2.5 clk = ~clk;

  boot_wp_ctrl #(.ADDR_W(AW), .BLK_W(BW), .DATA_W(DW), .TOP_BOOT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .lock_set(lock_set), .hv_override(hv_override),
    .op_done(done0), .op_allow(allow0), .erase_mask(mask0), .id_data(id0));

  boot_wp_ctrl #(.ADDR_W(AW), .BLK_W(BW), .DATA_W(DW), .TOP_BOOT(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .lock_set(lock_set), .hv_override(hv_override),
    .op_done(done1), .op_allow(allow1), .erase_mask(mask1), .id_data(id1));

  function automatic int region_of(input bit top, input int addr);
    int idx;
    idx = addr >> BW;
    if (top) idx = NBLK - 1 - idx;
    return (idx > 2) ? 3 : idx;
  endfunction

  function automatic void model(input bit top, input int kind, input int addr,
                                input bit lk, input bit hv, output bit al,
                                output logic [3:0] mk, output logic [DW-1:0] id);
    int rg;
    bit open_b;
    rg = region_of(top, addr);
    open_b = !lk || hv;
    al = 1'b0; mk = 4'b0; id = '0;
    case (kind)
      0: if (addr == 2) id = DW'(lk);
      1: al = (rg != 0) || open_b;
      2: begin
        if (rg == 1 || rg == 2) begin al = 1'b1; mk = 4'(1 << rg); end
        else if (open_b) begin al = 1'b1; mk = 4'b1001; end
        else if (rg == 3) begin al = 1'b1; mk = 4'b1000; end
      end
      default: if (open_b) begin al = 1'b1; mk = 4'b1111; end
    endcase
  endfunction

  task automatic check(input string tag, input bit top, input bit d, input bit al,
                       input logic [3:0] mk, input logic [DW-1:0] id, input bit ed,
                       input bit eal, input logic [3:0] emk, input logic [DW-1:0] eid);
    n_chk++;
    if (d !== ed || al !== eal || mk !== emk || id !== eid) begin
      n_bad++;
      $display("FAIL %s top=%0d kind=%0d addr=%0d hv=%0d: got done=%0b allow=%0b mask=%b id=%h, exp done=%0b allow=%0b mask=%b id=%h",
               tag, top, op_kind, op_addr, hv_override, d, al, mk, id, ed, eal, emk, eid);
    end
  endtask

  // Issue one request, then compare both instances one cycle later.
  task automatic do_op(input string tag, input int kind, input int addr, input bit hv,
                       input bit lk_for_model, input bit pulse_lock);
    bit al; logic [3:0] mk; logic [DW-1:0] id;
    @(negedge clk);
    op_valid = 1'b1; op_kind = 2'(kind); op_addr = AW'(addr);
    hv_override = hv; lock_set = pulse_lock;
    @(negedge clk);
    op_valid = 1'b0; lock_set = 1'b0;
    model(1'b0, kind, addr, lk_for_model, hv, al, mk, id);
    check(tag, 1'b0, done0, allow0, mask0, id0, 1'b1, al, mk, id);
    model(1'b1, kind, addr, lk_for_model, hv, al, mk, id);
    check(tag, 1'b1, done1, allow1, mask1, id1, 1'b1, al, mk, id);
    hv_override = 1'b0;
  endtask

  task automatic sweep(input bit lk);
    for (int hv = 0; hv < 2; hv++)
      for (int k = 0; k < 4; k++)
        for (int a = 0; a < (1 << AW); a++)
          do_op(lk ? "R1 R5 R6 R7 R8 R9 sweep-locked" : "R1 R2 R3 R4 R7 R9 sweep-open",
                k, a, hv[0], lk, 1'b0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    // R11: outputs are cleared while reset is held
    check("R11 reset", 1'b0, done0, allow0, mask0, id0, 1'b0, 1'b0, 4'b0, '0);
    check("R11 reset", 1'b1, done1, allow1, mask1, id1, 1'b0, 1'b0, 4'b0, '0);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    apply_reset();
    // R11: the lock reads as clear after power-on
    do_op("R11 R9 id after reset", 0, 2, 1'b0, 1'b0, 1'b0);
    // R12: an idle cycle gives quiet outputs
    @(negedge clk);
    check("R12 idle", 1'b0, done0, allow0, mask0, id0, 1'b0, 1'b0, 4'b0, '0);
    check("R12 idle", 1'b1, done1, allow1, mask1, id1, 1'b0, 1'b0, 4'b0, '0);

    sweep(1'b0);

    // R10: a chip erase in the same cycle as the lock pulse sees the old flag
    do_op("R10 same-cycle lock", 3, 40, 1'b0, 1'b0, 1'b1);
    do_op("R10 lock now active", 3, 40, 1'b0, 1'b1, 1'b0);
    do_op("R9 R10 id shows lock", 0, 2, 1'b0, 1'b1, 1'b0);
    do_op("R9 id other addr", 0, 3, 1'b0, 1'b1, 1'b0);

    // R8: the override opens the boot region for one request only
    do_op("R8 override program boot", 1, 0, 1'b1, 1'b1, 1'b0);
    do_op("R8 protection resumes", 1, 0, 1'b0, 1'b1, 1'b0);
    do_op("R8 override program top boot", 1, 63, 1'b1, 1'b1, 1'b0);
    do_op("R8 R6 resumes top boot", 1, 63, 1'b0, 1'b1, 1'b0);

    sweep(1'b1);

    // R10 R11: only reset clears the flag
    apply_reset();
    do_op("R10 R11 lock cleared by reset", 0, 2, 1'b0, 1'b0, 1'b0);
    do_op("R7 chip erase after reset", 3, 10, 1'b0, 1'b0, 1'b0);
    finish_run();
  end
endmodule